// File: doc/BRIEF.md
# Staged PWM Compare Register Updater

This block keeps the five compare values of a complementary PWM timer: the duty values and the carrier-cycle value. Each value passes through three stages: a software-visible buffer, a hidden holding stage and the active compare register that feeds the timer. Software may write any buffer at any time. The written values reach the holding stage only as a complete set. That happens when software writes the commit slot, and the copy waits while the subcounter is running.

The active compare registers reload from the holding stage only at the counter events picked by a 2-bit timing select: the crest, the trough, both, or neither. A set of values that has been committed only in part therefore never reaches the waveform logic. A pending output shows that a commit is waiting for the subcounter to stop.

Top module: `pwm_cmp_updater`

## Requirements
- R1: A synchronous reset clears every buffer, holding and compare register to zero and clears the pending flag.
- R2: A write to slot 0 to 4 (index `wrIdx`, data `wrData`, strobe `wrEn`) loads that slot's buffer in any cycle, whether or not the PWM is running. The write alone does not change any compare output.
- R3: Buffer writes to slots 0 to 3 leave the holding stage unchanged until the commit slot is written. A qualifying event before the commit leaves the outputs unchanged.
- R4: A write to commit slot 4 while `subRun` is low copies all five buffers into the holding stage at that clock edge. Slot 4 takes the data written in that same cycle.
- R5: A commit write while `subRun` is high sets `pending` at that edge and defers the copy. The copy happens at the first clock edge at which `subRun` is sampled low, and `pending` clears at that same edge.
- R6: Buffer writes accepted while `pending` is set are included in the deferred copy, so the copy uses the newest buffer contents.
- R7: Timing select `updSel` uses this encoding: 2'b01 updates on `crestPulse` only, 2'b10 on `troughPulse` only, 2'b11 on either pulse, and 2'b00 never updates.
- R8: On a qualifying event, all five compare outputs reload together from the holding stage. This happens only if the holding stage has been loaded since the last compare reload.
- R9: If a holding-stage load and a qualifying event fall on the same edge, the compare outputs take the previous holding values. The new values move to the compare stage at the next qualifying event.
- R10: A commit write that repeats the commit slot's previous value is handled exactly like any other commit.
- R11: Writes with index 5, 6 or 7 change no buffer and start no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrIdx | input | 3 | Slot index of the write (4 is the commit slot) |
| wrData | input | 16 | Write data |
| subRun | input | 1 | Subcounter running flag |
| crestPulse | input | 1 | Main counter crest event, one cycle |
| troughPulse | input | 1 | Main counter trough event, one cycle |
| updSel | input | 2 | Compare update timing select |
| cmpOut | output | 80 | Active compare values, slot i in bits [16*i+15:16*i] |
| pending | output | 1 | Deferred commit waiting for the subcounter to stop |

## Verification
The hardest situation to reach is a commit that lands on the same edge as a qualifying crest. That edge must leave the old holding values on the outputs, yet keep the new set armed for the next trough. The bench drives the commit write and the crest pulse in one cycle to create it. A second difficult case is a deferred commit that collects more buffer writes while the subcounter keeps running. The bench holds `subRun` high across several writes and events, then drops it. It checks that the copy picks up the newest data, and that events while the commit is pending change nothing.

// File: rtl/pwm_upd_pkg.sv
package pwm_upd_pkg;
  localparam int IDX_W = 3;

  typedef struct packed {
    logic             bufWr;
    logic [IDX_W-1:0] bufIdx;
    logic             tempLoad;
    logic             cmpLoad;
  } upd_strobe_t;
endpackage

// File: rtl/pwm_upd_ctrl.sv
module pwm_upd_ctrl
  import pwm_upd_pkg::*;
#(
  parameter int NUM_REGS   = 5,
  parameter int COMMIT_IDX = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             subRun,
  input  logic             crestPulse,
  input  logic             troughPulse,
  input  logic [1:0]       updSel,
  output upd_strobe_t      strobes,
  output logic             pending
);
  localparam logic [IDX_W-1:0] LastIdx   = IDX_W'(NUM_REGS - 1);
  localparam logic [IDX_W-1:0] CommitIdx = IDX_W'(COMMIT_IDX);

  logic pendQ;
  logic loadedQ;
  logic validWr;
  logic commitWr;
  logic evtHit;

  always_comb begin
    validWr  = wrEn && (wrIdx <= LastIdx);
    commitWr = validWr && (wrIdx == CommitIdx);
    evtHit   = (crestPulse && updSel[0]) || (troughPulse && updSel[1]);
    strobes.bufWr    = validWr;
    strobes.bufIdx   = wrIdx;
    strobes.tempLoad = !subRun && (commitWr || pendQ);
    strobes.cmpLoad  = evtHit && loadedQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ   <= 1'b0;
      loadedQ <= 1'b0;
    end else begin
      if (commitWr && subRun)    pendQ <= 1'b1;
      else if (strobes.tempLoad) pendQ <= 1'b0;

      if (strobes.tempLoad)     loadedQ <= 1'b1;
      else if (strobes.cmpLoad) loadedQ <= 1'b0;
    end
  end

  assign pending = pendQ;

  // R5: commit while subcounter runs must defer
  assert_defer_R5: assert property (@(posedge clk) disable iff (rst)
    (commitWr && subRun) |=> pendQ);
  // R5: pending persists while the subcounter keeps running
  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (pendQ && subRun) |=> pendQ);
  // R5: pending clears once the subcounter is seen stopped
  assert_pend_release_R5: assert property (@(posedge clk) disable iff (rst)
    (pendQ && !subRun) |=> !pendQ);
  // R7: disabled timing select never reloads compares
  assert_sel_off_R7: assert property (@(posedge clk) disable iff (rst)
    (updSel == 2'b00) |-> !strobes.cmpLoad);
endmodule

// File: rtl/pwm_upd_dp.sv
module pwm_upd_dp
  import pwm_upd_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int DATA_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  upd_strobe_t                  strobes,
  input  logic [DATA_W-1:0]            wrData,
  output logic [NUM_REGS*DATA_W-1:0]   cmpOut
);
  logic [DATA_W-1:0] bufQ  [NUM_REGS];
  logic [DATA_W-1:0] tempQ [NUM_REGS];
  logic [DATA_W-1:0] cmpQ  [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic hitWr;
    logic [DATA_W-1:0] bufNext;

    always_comb begin
      hitWr   = strobes.bufWr && (strobes.bufIdx == IDX_W'(i));
      bufNext = hitWr ? wrData : bufQ[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        bufQ[i]  <= '0;
        tempQ[i] <= '0;
        cmpQ[i]  <= '0;
      end else begin
        bufQ[i] <= bufNext;
        if (strobes.tempLoad) tempQ[i] <= bufNext;
        if (strobes.cmpLoad)  cmpQ[i]  <= tempQ[i];
      end
    end

    assign cmpOut[i*DATA_W +: DATA_W] = cmpQ[i];

    // R3: holding stage only moves on a commit copy
    assert_tmp_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !strobes.tempLoad |=> $stable(tempQ[i]));
    // R8: compare stage only moves on a qualified reload
    assert_cmp_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !strobes.cmpLoad |=> $stable(cmpQ[i]));
  end
endmodule

// File: rtl/pwm_cmp_updater.sv
module pwm_cmp_updater
  import pwm_upd_pkg::*;
#(
  parameter int NUM_REGS   = 5,
  parameter int DATA_W     = 16,
  parameter int COMMIT_IDX = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrEn,
  input  logic [IDX_W-1:0]           wrIdx,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       subRun,
  input  logic                       crestPulse,
  input  logic                       troughPulse,
  input  logic [1:0]                 updSel,
  output logic [NUM_REGS*DATA_W-1:0] cmpOut,
  output logic                       pending
);
  upd_strobe_t strobes;

  pwm_upd_ctrl #(.NUM_REGS(NUM_REGS), .COMMIT_IDX(COMMIT_IDX)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .subRun(subRun),
    .crestPulse(crestPulse), .troughPulse(troughPulse), .updSel(updSel),
    .strobes(strobes), .pending(pending)
  );

  pwm_upd_dp #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData), .cmpOut(cmpOut)
  );
endmodule

// File: tb/tb_pwm_cmp_updater.sv
module tb_pwm_cmp_updater;
  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic [2:0]  wrIdx;
  logic [15:0] wrData;
  logic        subRun;
  logic        crestPulse;
  logic        troughPulse;
  logic [1:0]  updSel;
  logic [79:0] cmpOut;
  logic        pending;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwm_cmp_updater dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .subRun(subRun), .crestPulse(crestPulse), .troughPulse(troughPulse),
    .updSel(updSel), .cmpOut(cmpOut), .pending(pending)
  );

  function automatic logic [15:0] cmpAt(int i);
    return cmpOut[i*16 +: 16];
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkVal(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic checkAll(string req, int e0, int e1, int e2, int e3, int e4);
    checkVal(req, "cmp0", cmpAt(0), e0);
    checkVal(req, "cmp1", cmpAt(1), e1);
    checkVal(req, "cmp2", cmpAt(2), e2);
    checkVal(req, "cmp3", cmpAt(3), e3);
    checkVal(req, "cmp4", cmpAt(4), e4);
  endtask

  task automatic writeReg(int idx, int data);
    wrEn = 1'b1; wrIdx = 3'(idx); wrData = 16'(data);
    tick();
    wrEn = 1'b0;
  endtask

  task automatic pulse(bit crest, bit trough);
    crestPulse = crest; troughPulse = trough;
    tick();
    crestPulse = 1'b0; troughPulse = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    checkAll("R1", 0, 0, 0, 0, 0);
    checkVal("R1", "pending", int'(pending), 0);
  endtask

  task automatic testBasicCommit();
    updSel = 2'b11;
    writeReg(0, 11); writeReg(1, 12); writeReg(2, 13); writeReg(3, 14);
    checkAll("R2", 0, 0, 0, 0, 0);
    pulse(1, 0);
    checkAll("R3", 0, 0, 0, 0, 0);
    writeReg(4, 15);
    checkAll("R4", 0, 0, 0, 0, 0);
    checkVal("R4", "pending", int'(pending), 0);
    pulse(0, 1);
    checkAll("R4", 11, 12, 13, 14, 15);
  endtask

  task automatic testTimingSelect();
    updSel = 2'b01;
    writeReg(0, 21); writeReg(4, 15);
    pulse(0, 1);
    checkVal("R7", "crest-only ignores trough", int'(cmpAt(0)), 11);
    pulse(1, 0);
    checkVal("R10", "same-value commit reaches cmp0", int'(cmpAt(0)), 21);
    updSel = 2'b10;
    writeReg(1, 22); writeReg(4, 15);
    pulse(1, 0);
    checkVal("R7", "trough-only ignores crest", int'(cmpAt(1)), 12);
    pulse(0, 1);
    checkVal("R7", "trough-only on trough", int'(cmpAt(1)), 22);
    updSel = 2'b00;
    writeReg(2, 23); writeReg(4, 15);
    pulse(1, 0); pulse(0, 1);
    checkVal("R7", "select off", int'(cmpAt(2)), 13);
    updSel = 2'b11;
    pulse(1, 0);
    checkAll("R7", 21, 22, 23, 14, 15);
  endtask

  task automatic testLoadGate();
    writeReg(3, 99);
    pulse(1, 0);
    checkVal("R8", "no reload without commit", int'(cmpAt(3)), 14);
    writeReg(4, 15);
    pulse(1, 0);
    checkVal("R8", "reload after commit", int'(cmpAt(3)), 99);
  endtask

  task automatic testDeferred();
    subRun = 1'b1;
    writeReg(0, 31);
    writeReg(4, 16);
    checkVal("R5", "pending set", int'(pending), 1);
    pulse(1, 0);
    checkAll("R5", 21, 22, 23, 99, 15);
    writeReg(1, 32);
    tick(); tick();
    checkVal("R5", "pending held", int'(pending), 1);
    subRun = 1'b0;
    tick();
    checkVal("R5", "pending cleared", int'(pending), 0);
    checkVal("R5", "cmp unchanged before event", int'(cmpAt(0)), 21);
    pulse(1, 0);
    checkAll("R6", 31, 32, 23, 99, 16);
  endtask

  task automatic testCollision();
    updSel = 2'b11;
    writeReg(2, 41);
    wrEn = 1'b1; wrIdx = 3'd4; wrData = 16'd16; crestPulse = 1'b1;
    tick();
    wrEn = 1'b0; crestPulse = 1'b0;
    checkVal("R9", "old holding value on collision", int'(cmpAt(2)), 23);
    pulse(0, 1);
    checkVal("R9", "new value next event", int'(cmpAt(2)), 41);
  endtask

  task automatic testBadIndex();
    writeReg(5, 500); writeReg(6, 600); writeReg(7, 700);
    pulse(1, 0);
    checkAll("R11", 31, 32, 41, 99, 16);
    writeReg(4, 50);
    pulse(0, 1);
    checkAll("R11", 31, 32, 41, 99, 50);
  endtask

  task automatic testMidReset();
    writeReg(0, 77); writeReg(4, 78);
    doReset();
    checkAll("R1", 0, 0, 0, 0, 0);
    pulse(1, 1);
    checkAll("R1", 0, 0, 0, 0, 0);
  endtask

  initial begin
    wrEn = 1'b0; wrIdx = '0; wrData = '0; subRun = 1'b0;
    crestPulse = 1'b0; troughPulse = 1'b0; updSel = 2'b11; rst = 1'b1;
    @(negedge clk);
    testReset();
    testBasicCommit();
    testTimingSelect();
    testLoadGate();
    testDeferred();
    testCollision();
    testBadIndex();
    testMidReset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule